// File: doc/BRIEF.md
# Link Pulse Page Receiver with Match Detection

This block sits behind the line receiver's pulse detector during link setup. Each link pulse reaches it as a single-cycle strobe. It sorts every pulse into one of two kinds by measuring the gap since the last clock pulse: either a framing clock pulse or a data pulse. It frames each burst as 17 clock pulses, with up to 16 data positions between them, and assembles a 16-bit page from those data positions.

A burst that stops early, or that carries two data pulses in one interval, is dropped and flagged with an error strobe. A complete page is presented with a one-cycle valid strobe. The page is also compared with the page before it, so that the capability logic downstream only acts once a page has been seen unchanged several times in a row.

All timing is counted in clock cycles. The nominal slot spacing and the timeout are parameters, so simulation can use short values.

Top module: `lp_page_rx`

## Requirements
- R1: After reset, `page_vld`, `burst_err` and `ab_match` are 0, and `page_data` and `match_page` are all zeros.
- R2: When no burst is in progress, the first pulse opens a burst as clock pulse one. Within a burst, a pulse that arrives more than THRESH = 3*SLOT_CYC/2 cycles after the last clock pulse is the next clock pulse. With the default parameters, THRESH is 12.
- R3: A pulse that arrives 1 to THRESH cycles after a clock pulse is a data pulse, and it makes that interval's bit 1. An interval with no data pulse gives bit 0.
- R4: The 17th clock pulse ends the burst. In the cycle after that pulse is sampled, `page_vld` is high for exactly one cycle. `page_data` then holds the 16 bits, with the bit of the first interval at bit 0, and the rest in order up to bit 15.
- R5: A clock pulse may arrive as late as TOUT_CYC cycles after the previous one. If it has not arrived by then, the burst is dropped, `burst_err` pulses for one cycle, and no page is produced.
- R6: A second data pulse inside one clock interval drops the burst at once. `burst_err` is high in the following cycle, and no page is produced.
- R7: The identical-page counter advances on each complete page that equals the previous complete page. `ab_match` goes high together with the `page_vld` of the MATCH_NEED-th consecutive identical page (3 by default). It stays high while further identical pages arrive.
- R8: A complete page that differs from the previous one resets the counter to one. `ab_match` clears in the same cycle as that page's `page_vld`.
- R9: A dropped burst (R5, R6) leaves `ab_match`, `match_page` and the counter unchanged.
- R10: `match_page` holds the most recent complete page. While `ab_match` is high, it is the matched page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Single-cycle link pulse detected strobe |
| page_vld | output | 1 | One-cycle strobe, page complete |
| page_data | output | PAGE_W | Last decoded page, LSB first on the line |
| burst_err | output | 1 | One-cycle strobe, malformed burst dropped |
| ab_match | output | 1 | Page seen identically MATCH_NEED times in a row |
| match_page | output | PAGE_W | Most recent complete page |

## Verification
Every result is registered once. `page_vld`, `page_data`, `ab_match` and `match_page` update on the edge that samples the 17th clock pulse. A double data pulse raises `burst_err` on the edge that samples the second data pulse. A timeout raises `burst_err` TOUT_CYC edges after the edge of the last clock pulse. The bench drives pulses on falling edges and records the strobes on falling edges. It checks each burst's outcome only after a settle margin longer than the latest of these due points, and that margin is shorter than the gap before the next burst.

// File: rtl/lp_page_rx.sv
module lp_page_rx #(
  parameter int SLOT_CYC   = 8,
  parameter int TOUT_CYC   = 32,
  parameter int PAGE_W     = 16,
  parameter int MATCH_NEED = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_in,
  output logic              page_vld,
  output logic [PAGE_W-1:0] page_data,
  output logic              burst_err,
  output logic              ab_match,
  output logic [PAGE_W-1:0] match_page
);
  localparam int THRESH = (3 * SLOT_CYC) / 2;
  localparam int GW = $clog2(TOUT_CYC + 1);
  localparam int CW = $clog2(PAGE_W + 2);
  localparam int MW = $clog2(MATCH_NEED + 1);
  localparam logic [GW-1:0] THR_G  = GW'(THRESH);
  localparam logic [GW-1:0] TOUT_G = GW'(TOUT_CYC);
  localparam logic [CW-1:0] LAST_G = CW'(PAGE_W);
  localparam logic [MW-1:0] MAX_M  = MW'(MATCH_NEED);
  localparam logic [MW-1:0] PRE_M  = MW'(MATCH_NEED - 1);
  localparam logic          ONE_OK = (MATCH_NEED <= 1);

  logic              in_burst;
  logic [CW-1:0]     clk_cnt;
  logic [GW-1:0]     gap;
  logic              dat_seen;
  logic [PAGE_W-1:0] shreg;
  logic [MW-1:0]     same_cnt;

  wire is_clk  = pulse_in && (!in_burst || gap > THR_G);
  wire is_dat  = pulse_in && in_burst && gap <= THR_G;
  wire dup_dat = is_dat && dat_seen;
  wire tmo     = in_burst && !pulse_in && gap == TOUT_G;
  wire done    = is_clk && in_burst && clk_cnt == LAST_G;
  wire [PAGE_W-1:0] word = {dat_seen, shreg[PAGE_W-1:1]};
  wire same    = same_cnt != '0 && word == match_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst   <= 1'b0;
      clk_cnt    <= '0;
      gap        <= '0;
      dat_seen   <= 1'b0;
      shreg      <= '0;
      same_cnt   <= '0;
      page_vld   <= 1'b0;
      page_data  <= '0;
      burst_err  <= 1'b0;
      ab_match   <= 1'b0;
      match_page <= '0;
    end else begin
      page_vld  <= 1'b0;
      burst_err <= 1'b0;
      if (!in_burst) begin
        if (pulse_in) begin
          in_burst <= 1'b1;
          clk_cnt  <= CW'(1);
          gap      <= GW'(1);
          dat_seen <= 1'b0;
        end
      end else if (tmo || dup_dat) begin
        in_burst  <= 1'b0;
        burst_err <= 1'b1;
      end else if (is_clk) begin
        shreg    <= word;
        dat_seen <= 1'b0;
        gap      <= GW'(1);
        if (done) begin
          in_burst   <= 1'b0;
          page_vld   <= 1'b1;
          page_data  <= word;
          match_page <= word;
          same_cnt   <= same ? ((same_cnt == MAX_M) ? same_cnt : same_cnt + MW'(1)) : MW'(1);
          ab_match   <= same ? (same_cnt >= PRE_M) : ONE_OK;
        end else begin
          clk_cnt <= clk_cnt + CW'(1);
        end
      end else begin
        gap <= gap + GW'(1);
        if (is_dat) dat_seen <= 1'b1;
      end
    end
  end

  p_vld_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_vld |=> !page_vld);
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |=> !burst_err);
  p_err_no_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_err && page_vld));
  p_match_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ab_match) |-> page_vld);
  p_match_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ab_match) |-> page_vld);
  p_drop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |-> ($stable(ab_match) && $stable(match_page)));
  p_match_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
    page_vld |-> match_page == page_data);
endmodule

// File: tb/lp_page_rx_bench.sv
`timescale 1ns/1ps
module lp_page_rx_bench;
  localparam int SLOT = 8;
  localparam int TOUT = 32;
  localparam int THR  = (3 * SLOT) / 2;
  localparam int NEED = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic page_vld, burst_err, ab_match;
  logic [15:0] page_data, match_page;

  always #2 clk = ~clk;

  lp_page_rx #(.SLOT_CYC(SLOT), .TOUT_CYC(TOUT), .PAGE_W(16), .MATCH_NEED(NEED)) u_lp_page_rx (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .page_vld(page_vld),
    .page_data(page_data), .burst_err(burst_err), .ab_match(ab_match),
    .match_page(match_page));

  int checks = 0, errors = 0, vld_n = 0, err_n = 0;
  logic [15:0] got_word;
  logic got_match;
  logic [15:0] ref_prev = '0;
  int ref_cnt = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_n) begin
    if (page_vld) begin vld_n++; got_word = page_data; got_match = ab_match; end
    if (burst_err) err_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wait_cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic hit(); pulse_in = 1'b1; @(negedge clk); pulse_in = 1'b0; endtask

  task automatic send(input logic [15:0] w, input int nclk, input int fc, input int fd);
    for (int k = 1; k <= nclk; k++) begin
      hit();
      if (k < nclk) begin
        int c, d;
        c = (fc > 0) ? fc : $urandom_range(THR + 8, THR + 1);
        d = (fd > 0) ? fd : $urandom_range(THR, 1);
        if (w[k-1]) begin wait_cyc(d - 1); hit(); wait_cyc(c - d - 1); end
        else wait_cyc(c - 1);
      end
    end
  endtask

  function automatic bit model(input logic [15:0] w);
    if (ref_cnt != 0 && w == ref_prev) ref_cnt = (ref_cnt < NEED) ? ref_cnt + 1 : ref_cnt;
    else begin ref_cnt = 1; ref_prev = w; end
    return ref_cnt >= NEED;
  endfunction

  task automatic good(input logic [15:0] w, input int fc, input int fd, input string req);
    int v0, e0;
    bit em;
    v0 = vld_n; e0 = err_n;
    send(w, 17, fc, fd);
    wait_cyc(3);
    em = model(w);
    chk(vld_n == v0 + 1, {req, " R4 page count"}, vld_n, v0 + 1);
    chk(got_word == w, {req, " R3 page word"}, got_word, w);
    chk(got_match == em, {req, " R7/R8 match with strobe"}, got_match, em);
    chk(ab_match == em && match_page == w, {req, " R10 match page"}, match_page, w);
    chk(err_n == e0, {req, " no error"}, err_n, e0);
    wait_cyc(10);
  endtask

  task automatic bad_trunc(input logic [15:0] w, input int nclk);
    int v0, e0;
    logic m0;
    logic [15:0] p0;
    v0 = vld_n; e0 = err_n; m0 = ab_match; p0 = match_page;
    send(w, nclk, 0, 0);
    wait_cyc(TOUT + 5);
    chk(err_n == e0 + 1, "R5 timeout error", err_n, e0 + 1);
    chk(vld_n == v0, "R5 no page on timeout", vld_n, v0);
    chk(ab_match == m0 && match_page == p0, "R9 drop keeps match", match_page, p0);
    wait_cyc(5);
  endtask

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(3);
    chk(page_vld == 0 && burst_err == 0 && ab_match == 0, "R1 reset strobes", {page_vld, burst_err, ab_match}, 0);
    chk(page_data == 0 && match_page == 0, "R1 reset words", page_data, 0);
    rst_n = 1'b1;
    wait_cyc(3);
    good(16'hA5C3, 0, 0, "R2 first");
    good(16'hA5C3, THR + 1, THR, "R2 boundary gap");
    good(16'hA5C3, TOUT, 1, "R5 max gap");
    good(16'hA5C3, 0, 0, "R7 stays");
    good(16'h0000, 0, 0, "R8 all zero");
    good(16'hFFFF, 0, 0, "R3 all one");
    good(16'hFFFF, 0, 0, "R7 second");
    bad_trunc(16'h1234, 9);
    good(16'hFFFF, 0, 0, "R9 count kept");
    begin
      int v0, e0;
      logic m0;
      v0 = vld_n; e0 = err_n; m0 = ab_match;
      hit(); wait_cyc(2); hit(); wait_cyc(2); hit(); wait_cyc(5);
      chk(err_n == e0 + 1, "R6 double data error", err_n, e0 + 1);
      chk(vld_n == v0 && ab_match == m0, "R6 R9 no page", vld_n, v0);
      wait_cyc(5);
    end
    bad_trunc(16'h5555, 1);
    bad_trunc(16'h5555, 16);
    good(16'h0001, 0, 0, "R4 lsb first");
    good(16'h8000, 0, 0, "R4 msb last");
    for (int i = 0; i < 40; i++) begin
      int sel;
      logic [15:0] w;
      sel = $urandom_range(9, 0);
      w = (sel < 5) ? ref_prev : 16'($urandom);
      if (sel == 9) bad_trunc(w, $urandom_range(16, 1));
      else good(w, 0, 0, "R7 random");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule